// File: doc/BRIEF.md
# SPI Serial EEPROM Page-Write Target

This block is the target end of a serial EEPROM on a mode-0 SPI bus. Chip select, serial clock and serial input are brought into the system clock domain and oversampled there. The block decodes three commands: set the write-enable latch, page write, and status read. Page-write data is staged in a 256-byte page buffer that records which offsets were written. After a valid frame the block enters a self-timed busy interval. During that interval the staged bytes are copied into a small on-chip array, and page bytes that were not sent keep their old contents.

Software sets the latch in its own frame. It then sends the write command, a 24-bit address and up to a page of data, and raises chip select on a byte boundary. It polls the status byte until the in-progress bit clears. A separate parallel read port gives the rest of the chip access to the array. That port reports a refusal while a commit is running.

Top module: `eep_write_engine`

## Requirements
- R1: The status byte carries write-in-progress in bit 0 and the write-enable latch in bit 1. Bits 3:2 are the block-protect field and bit 7 the protect-enable flag; both always read 0, as do all other bits. After reset the status byte is 0x00.
- R2: The enable command (0x06) sets the latch only if chip select rises with exactly those 8 bits clocked in the frame. A write command that follows it in the same frame is not executed, and the latch stays clear.
- R3: A write command (0x02) issued while the latch is clear is ignored. No busy interval starts and the array is unchanged.
- R4: The 24-bit address follows the opcode, MSB first. Its low 8 bits are the offset within the page. Address bits above the array size, including the top seven, are ignored.
- R5: Data bytes are stored at consecutive offsets. The offset wraps from 0xFF to 0x00 of the same page, and a later byte overwrites an earlier byte at the same offset.
- R6: A write commits only if chip select rises right after bit D0 of a data byte. Any other rise discards the frame: no busy interval, and the latch is unchanged.
- R7: Page bytes that were not sent in the committed frame keep their previous values.
- R8: While busy, the status reads 0x03 and the read port reports refusal (rd_ok = 0). Write and enable commands are ignored.
- R9: The busy interval lasts BUSY_CYCLES clock cycles. At its end the in-progress bit and the latch both clear.
- R10: After the status command (0x05), SO is enabled and changes on SCK falling edges, MSB first. The byte repeats with its live value for as long as chip select stays low. so_oe is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for so; 0 means high impedance |
| rd_addr | input | $clog2(PAGE_BYTES*NUM_PAGES) | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |
| rd_ok | output | 1 | 1 when the array is readable (no commit running) |

## Verification
The hardest condition to reach is the busy window. During a single commit the stimulus must read the status, see the read port refuse access, and push a complete write frame that has to be rejected. BUSY_CYCLES is therefore set long enough to fit a status frame and a five-byte write frame back to back after chip select rises. Page wrap with overwrite needs 258 data bytes in one frame, so that the first two offsets are written twice. That frame also carries an address with the top bits set. A frame cut off three bits into a data byte exercises the discard path and shows that the latch survives it.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_DATA,
        PH_STAT,
        PH_SKIP
    } phase_e;

    localparam logic [7:0] OPC_SET_WEL = 8'h06;
    localparam logic [7:0] OPC_WRITE   = 8'h02;
    localparam logic [7:0] OPC_STATUS  = 8'h05;

    localparam int ST_WIP = 0;
    localparam int ST_WEL = 1;
    localparam logic [1:0] ST_BP_VAL   = 2'b00;
    localparam logic       ST_WPEN_VAL = 1'b0;
endpackage

// File: rtl/eep_spi_sync.sv
module eep_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic cs_n_s,
    output logic si_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_fall
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] RST_VEC = 3'b001;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] syn;
    logic [NSIG-1:0] prev_q;

    assign raw = {si, sck, cs_n};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VEC[g]}};
            else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        end
        assign syn[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VEC;
        else        prev_q <= syn;
    end

    assign cs_n_s   = syn[0];
    assign si_s     = syn[2];
    assign sck_rise = syn[1] & ~prev_q[1];
    assign sck_fall = ~syn[1] & prev_q[1];
    assign cs_rise  = syn[0] & ~prev_q[0];
    assign cs_fall  = ~syn[0] & prev_q[0];
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic          rd_mask
);
    logic [7:0]       store_q [DEPTH];
    logic [DEPTH-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mask_q <= '0;
        else if (clr)   mask_q <= '0;
        else if (wr_en) mask_q[wr_idx] <= 1'b1;
    end

    assign rd_data = store_q[rd_idx];
    assign rd_mask = mask_q[rd_idx];
endmodule

// File: rtl/eep_mem_array.sv
module eep_mem_array #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'h00;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/eep_write_engine.sv
module eep_write_engine #(
    parameter int PAGE_BYTES  = 256,
    parameter int NUM_PAGES   = 4,
    parameter int BUSY_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    cs_n,
    input  logic                                    sck,
    input  logic                                    si,
    output logic                                    so,
    output logic                                    so_oe,
    input  logic [$clog2(PAGE_BYTES*NUM_PAGES)-1:0] rd_addr,
    output logic [7:0]                              rd_data,
    output logic                                    rd_ok
);
    import eep_pkg::*;

    localparam int MEM_BYTES = PAGE_BYTES * NUM_PAGES;
    localparam int MEM_AW    = $clog2(MEM_BYTES);
    localparam int PG_AW     = $clog2(PAGE_BYTES);
    localparam int PGN_AW    = MEM_AW - PG_AW;
    localparam int CW        = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        phase_e            phase;
        logic [2:0]        bit_cnt;
        logic [7:0]        sh;
        logic [1:0]        addr_bytes;
        logic [MEM_AW-1:0] addr;
        logic [PG_AW-1:0]  ptr;
        logic [PGN_AW-1:0] page;
        logic              data_seen;
        logic              wel_armed;
        logic              wel;
        logic              busy;
        logic [CW-1:0]     cnt;
        logic [2:0]        out_bit;
        logic [7:0]        out_byte;
        logic              so;
        logic              so_en;
    } state_t;

    state_t state_d, state_q;

    logic cs_n_s, si_s, sck_rise, sck_fall, cs_rise, cs_fall;
    logic             buf_clr, buf_wr;
    logic [PG_AW-1:0] buf_widx;
    logic [7:0]       buf_wdata;
    logic [7:0]       buf_rdata;
    logic             buf_rmask;
    logic             mem_we;
    logic [7:0]       status;
    logic [7:0]       byte_v;
    logic [MEM_AW-1:0] addr_v;

    eep_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .cs_n_s(cs_n_s), .si_s(si_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_rise(cs_rise), .cs_fall(cs_fall)
    );

    eep_page_buf #(.DEPTH(PAGE_BYTES), .AW(PG_AW)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
        .wr_idx(buf_widx), .wr_data(buf_wdata),
        .rd_idx(state_q.cnt[PG_AW-1:0]), .rd_data(buf_rdata), .rd_mask(buf_rmask)
    );

    eep_mem_array #(.DEPTH(MEM_BYTES), .AW(MEM_AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we),
        .waddr({state_q.page, state_q.cnt[PG_AW-1:0]}), .wdata(buf_rdata),
        .raddr(rd_addr), .rdata(rd_data)
    );

    always_comb begin
        status         = 8'h00;
        status[ST_WIP] = state_q.busy;
        status[ST_WEL] = state_q.wel;
        status[3:2]    = ST_BP_VAL;
        status[7]      = ST_WPEN_VAL;
    end

    always_comb begin
        state_d   = state_q;
        buf_clr   = 1'b0;
        buf_wr    = 1'b0;
        buf_widx  = state_q.ptr;
        buf_wdata = 8'h00;
        mem_we    = 1'b0;
        byte_v    = {state_q.sh[6:0], si_s};
        addr_v    = {state_q.addr[MEM_AW-9:0], byte_v};

        // self-timed commit: one page offset per cycle, then hold until done
        if (state_q.busy) begin
            if (state_q.cnt < CW'(PAGE_BYTES)) mem_we = buf_rmask;
            state_d.cnt = state_q.cnt + 1'b1;
            if (state_q.cnt == CW'(BUSY_CYCLES - 1)) begin
                state_d.busy = 1'b0;
                state_d.wel  = 1'b0;
                state_d.cnt  = '0;
            end
        end

        if (cs_fall) begin
            state_d.phase      = PH_OPC;
            state_d.bit_cnt    = 3'd0;
            state_d.addr_bytes = 2'd0;
            state_d.data_seen  = 1'b0;
            state_d.wel_armed  = 1'b0;
            state_d.out_bit    = 3'd0;
            state_d.so_en      = 1'b0;
        end else if (cs_rise) begin
            if (state_q.wel_armed && !state_q.busy) state_d.wel = 1'b1;
            if (state_q.phase == PH_DATA && state_q.bit_cnt == 3'd0 &&
                state_q.data_seen && !state_q.busy) begin
                state_d.busy = 1'b1;
                state_d.cnt  = '0;
            end
            state_d.phase = PH_SKIP;
            state_d.so_en = 1'b0;
        end else if (!cs_n_s) begin
            if (sck_rise) begin
                state_d.sh        = byte_v;
                state_d.bit_cnt   = state_q.bit_cnt + 1'b1;
                state_d.wel_armed = 1'b0;
                if (state_q.bit_cnt == 3'd7) begin
                    unique case (state_q.phase)
                        PH_OPC: begin
                            state_d.phase = PH_SKIP;
                            if (byte_v == OPC_SET_WEL) begin
                                state_d.wel_armed = !state_q.busy;
                            end else if (byte_v == OPC_WRITE) begin
                                if (state_q.wel && !state_q.busy) state_d.phase = PH_ADDR;
                            end else if (byte_v == OPC_STATUS) begin
                                state_d.phase = PH_STAT;
                            end
                        end
                        PH_ADDR: begin
                            state_d.addr       = addr_v;
                            state_d.addr_bytes = state_q.addr_bytes + 1'b1;
                            if (state_q.addr_bytes == 2'd2) begin
                                state_d.phase = PH_DATA;
                                state_d.ptr   = addr_v[PG_AW-1:0];
                                state_d.page  = addr_v[MEM_AW-1:PG_AW];
                                buf_clr       = 1'b1;
                            end
                        end
                        PH_DATA: begin
                            buf_wr            = 1'b1;
                            buf_wdata         = byte_v;
                            state_d.ptr       = state_q.ptr + 1'b1;
                            state_d.data_seen = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (sck_fall && state_q.phase == PH_STAT) begin
                if (state_q.out_bit == 3'd0) begin
                    state_d.out_byte = status;
                    state_d.so       = status[7];
                end else begin
                    state_d.so = state_q.out_byte[3'd7 - state_q.out_bit];
                end
                state_d.out_bit = state_q.out_bit + 1'b1;
                state_d.so_en   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.phase <= PH_SKIP;
        end else begin
            state_q <= state_d;
        end
    end

    assign so    = state_q.so;
    assign so_oe = state_q.so_en;
    assign rd_ok = !state_q.busy;
endmodule

// File: rtl/eep_write_chk.sv
module eep_write_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_s,
    input logic cs_rise,
    input logic busy,
    input logic wel,
    input logic so_oe,
    input logic mem_we,
    input logic in_data,
    input logic bit_zero,
    input logic data_seen
);
    a_r9_wel_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wel);

    a_r9_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    a_r10_so_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !so_oe);

    a_r8_store_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    a_r6_commit_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise && in_data && bit_zero && data_seen));

    a_r3_commit_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));
endmodule

bind eep_write_engine eep_write_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .cs_rise(cs_rise),
    .busy(state_q.busy), .wel(state_q.wel), .so_oe(so_oe), .mem_we(mem_we),
    .in_data(state_q.phase == eep_pkg::PH_DATA),
    .bit_zero(state_q.bit_cnt == 3'd0), .data_seen(state_q.data_seen)
);

// File: tb/eep_write_engine_tb_top.sv
module eep_write_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 5;
    localparam int BUSY       = 2000;
    localparam int AW         = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic so, so_oe, rd_ok;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_v[$];
    string      exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eep_write_engine #(.PAGE_BYTES(256), .NUM_PAGES(4), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ok(rd_ok)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic frame_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2*HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            si = b[i];
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic send_addr(input logic [23:0] a);
        send_byte(a[23:16]);
        send_byte(a[15:8]);
        send_byte(a[7:0]);
    endtask

    task automatic set_wel();
        frame_begin();
        send_byte(8'h06);
        frame_end();
    endtask

    // driver side of the scoreboard: queue expected status bytes, then clock them out
    task automatic read_status(input logic [7:0] e0, input int n, input string tag);
        frame_begin();
        send_byte(8'h05);
        for (int k = 0; k < n; k++) begin
            exp_v.push_back(e0);
            exp_tag.push_back(tag);
            send_byte(8'h00);
        end
        frame_end();
    endtask

    task automatic check_mem(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(rd_ok === 1'b1 && rd_data === e, tag, int'(rd_data), int'(e));
    endtask

    // monitor side: assemble SO bits on SCK rise, pop and compare
    initial begin
        int mcnt = 0;
        logic [7:0] mbyte = '0;
        forever begin
            @(posedge sck or posedge cs_n);
            if (cs_n) begin
                mcnt = 0;
            end else if (so_oe) begin
                mbyte = {mbyte[6:0], so};
                mcnt++;
                if (mcnt == 8) begin
                    mcnt = 0;
                    if (exp_v.size() == 0) begin
                        chk(1'b0, "R10 unexpected status byte", int'(mbyte), 0);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = exp_v.pop_front();
                        t = exp_tag.pop_front();
                        chk(mbyte === e, t, int'(mbyte), int'(e));
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // reset state
        chk(so_oe === 1'b0, "R10 so_oe idle after reset", int'(so_oe), 0);
        chk(rd_ok === 1'b1, "R1 rd_ok after reset", int'(rd_ok), 1);
        read_status(8'h00, 1, "R1 reset status");
        chk(so_oe === 1'b0, "R10 so_oe off after status frame", int'(so_oe), 0);
        check_mem(10'h000, 8'h00, "R1 array cleared");

        // write with latch clear
        frame_begin();
        send_byte(8'h02); send_addr(24'h000020); send_byte(8'h99);
        frame_end();
        wait_clk(50);
        read_status(8'h00, 1, "R3 no busy without latch");
        check_mem(10'h020, 8'h00, "R3 array untouched");

        // enable and write in one frame
        frame_begin();
        send_byte(8'h06); send_byte(8'h02); send_addr(24'h000021); send_byte(8'h55);
        frame_end();
        wait_clk(50);
        read_status(8'h00, 1, "R2 latch clear after merged frame");
        check_mem(10'h021, 8'h00, "R2 merged write not done");

        // plain enable; two status bytes in one frame
        set_wel();
        read_status(8'h02, 2, "R10 repeated status R2 latch set");

        // aborted frame: three bits into the data byte
        frame_begin();
        send_byte(8'h02); send_addr(24'h000300); send_bits(8'hAB, 3);
        frame_end();
        wait_clk(50);
        read_status(8'h02, 1, "R6 discard keeps latch, no busy");
        check_mem(10'h300, 8'h00, "R6 discarded byte absent");

        // valid write, then probe the busy window
        frame_begin();
        send_byte(8'h02); send_addr(24'h000105);
        send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC);
        frame_end();
        read_status(8'h03, 1, "R8 status during busy");
        @(negedge clk); #1;
        chk(rd_ok === 1'b0, "R8 read refused while busy", int'(rd_ok), 0);
        frame_begin();
        send_byte(8'h02); send_addr(24'h000010); send_byte(8'h77);
        frame_end();
        wait_clk(BUSY + 100);
        read_status(8'h00, 1, "R9 WIP and latch clear after busy");
        check_mem(10'h105, 8'hAA, "R5 byte 0");
        check_mem(10'h106, 8'hBB, "R5 byte 1");
        check_mem(10'h107, 8'hCC, "R4 R5 byte 2");
        check_mem(10'h104, 8'h00, "R7 below range kept");
        check_mem(10'h108, 8'h00, "R7 above range kept");
        check_mem(10'h010, 8'h00, "R8 write during busy ignored");

        // partial rewrite keeps neighbours
        set_wel();
        frame_begin();
        send_byte(8'h02); send_addr(24'h000106); send_byte(8'h5C);
        frame_end();
        wait_clk(BUSY + 100);
        check_mem(10'h105, 8'hAA, "R7 neighbour low kept");
        check_mem(10'h106, 8'h5C, "R7 target updated");
        check_mem(10'h107, 8'hCC, "R7 neighbour high kept");

        // 258 bytes from offset 0xFE with top address bits set
        set_wel();
        frame_begin();
        send_byte(8'h02); send_addr(24'hFE02FE);
        for (int k = 0; k < 258; k++) send_byte(8'((k < 256) ? k : k - 256 + 8'h40));
        frame_end();
        wait_clk(BUSY + 100);
        check_mem(10'h2FE, 8'h40, "R5 wrap overwrite first");
        check_mem(10'h2FF, 8'h41, "R5 wrap overwrite second");
        check_mem(10'h200, 8'h02, "R5 wrapped to page start");
        check_mem(10'h280, 8'h82, "R4 offset mapping");
        check_mem(10'h300, 8'h00, "R5 next page untouched");
        check_mem(10'h0FE, 8'h00, "R4 top bits ignored, page 0 untouched");
        read_status(8'h00, 1, "R9 status after long write");

        wait_clk(20);
        chk(exp_v.size() == 0, "R10 all status bytes seen", exp_v.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule